// File: doc/BRIEF.md
# Flash Endurance Cycling Sequencer

This block runs an endurance test on a flash array. It repeatedly erases and reprograms a small sample of blocks until each one wears out. The sample is spread across the array on a diagonal stride. In every pass, each sample still in service gets one whole-block erase. Program operations then follow for every page of that block, in ascending page order. Only one operation is in flight at a time, and its outcome is checked before the next one is issued.

A sample is retired when an operation reports a fail status or does not finish within its programmed time limit. An erase that takes too long is the usual sign of wear. A retired sample is skipped in every later pass. The pass number at which it failed is stored in a small on-chip memory. When no sample remains in service, the stored pass numbers are added up and divided by the sample count. The truncated mean is presented as the endurance figure, together with a one-cycle valid strobe.

Top module: `endurance_sequencer`

## Requirements
- R1: After reset, `busy`, `op_start` and `result_valid` are low.
- R2: `start` is taken only while `busy` is low. A `start` pulse during a run leaves the operation stream and the result unchanged.
- R3: Sample i (0 ≤ i < S) uses block address (i·⌊T/S⌋ + i) mod T, where T is `total_blocks` and S is `sample_count`. The samples are visited in ascending i within each pass.
- R4: For every sample in service, a pass issues one erase (`op_kind`=0, `op_page`=0) and then programs (`op_kind`=1) pages 0 to PAGES-1 in ascending order.
- R5: `op_start` is high for a single cycle. No new operation starts until the current one has finished or timed out.
- R6: `op_done` with `op_fail`=1 retires the sample and records the current pass number. The rest of that sample's operations in the pass are skipped, and the sample is not addressed again.
- R7: An operation with no `op_done` within its limit (`erase_limit` cycles for an erase, `prog_limit` cycles for a program) is handled exactly as a fail status.
- R8: The pass counter starts at 1. It advances only after all samples in service have been handled in the current pass.
- R9: When every sample has failed, `result_avg` is ⌊(sum of recorded pass numbers)/S⌋. `result_valid` pulses for one cycle while `busy` goes low. The result then holds until the next run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a run (only honoured when idle) |
| total_blocks | input | BLK_AW+1 | Number of blocks in the array (T) |
| sample_count | input | SI_W | Number of sampled blocks (S), 1 to MAX_SAMPLES |
| erase_limit | input | TMO_W | Erase timeout in clock cycles |
| prog_limit | input | TMO_W | Program timeout in clock cycles |
| op_start | output | 1 | One-cycle request to the flash port |
| op_kind | output | 1 | 0 = block erase, 1 = page program |
| op_block | output | BLK_AW | Target block address |
| op_page | output | PG_W | Target page within the block |
| op_done | input | 1 | Operation finished |
| op_fail | input | 1 | Status with `op_done`: 1 = failed |
| busy | output | 1 | High for the whole run |
| result_valid | output | 1 | One-cycle strobe when the average is ready |
| result_avg | output | CYC_W | Mean failure pass number |

## Verification
Each sample in the bench has its own wear model, so the three exit paths can be told apart. The first model returns a failing status on an erase from a given pass onward. The second lets an erase run past the limit with no answer. The third fails one page program in the middle of a block, which proves that the remaining pages are skipped. One run has four samples and a first-pass failure. A second run has three samples on a non-power-of-two array and exercises the timeout. A third run has a single sample. Together they separate the address stride, the retirement order and truncation in the average. A `start` pulse in mid-run checks that a busy sequencer ignores it.

// File: rtl/endurance_pkg.sv
package endurance_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_STRIDE, ST_SEL, ST_ISSUE, ST_WAIT, ST_SUM, ST_DIV
  } seq_state_t;

  localparam logic OPK_ERASE = 1'b0;
  localparam logic OPK_PROG  = 1'b1;
endpackage

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int W = 37
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         done,
  output logic [W-1:0] quo
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, q_q, d_q;
  logic [CW-1:0] cnt_q;
  logic          run_q, done_q;
  logic [W:0]    shifted, diff;
  logic          ge;

  always_comb begin
    shifted = {rem_q, q_q[W-1]};
    ge      = shifted >= {1'b0, d_q};
    diff    = shifted - {1'b0, d_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      q_q    <= '0;
      d_q    <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go) begin
        q_q   <= num;
        d_q   <= den;
        rem_q <= '0;
        cnt_q <= CW'(W);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= ge ? diff[W-1:0] : shifted[W-1:0];
        q_q   <= {q_q[W-2:0], ge};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done = done_q;
  assign quo  = q_q;

  AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (rst)
    go |-> den != '0); // R9
endmodule

// File: rtl/sample_addr_walker.sv
module sample_addr_walker #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          adv,
  input  logic [AW:0]   total,
  input  logic [AW+1:0] step,
  output logic [AW:0]   addr
);
  logic [AW:0]   addr_q;
  logic [AW+1:0] sum, wrapped;

  always_comb begin
    sum     = {1'b0, addr_q} + step;
    wrapped = (sum >= {1'b0, total}) ? sum - {1'b0, total} : sum;
  end

  always_ff @(posedge clk) begin
    if (rst || load) addr_q <= '0;
    else if (adv)    addr_q <= wrapped[AW:0];
  end

  assign addr = addr_q;
endmodule

// File: rtl/fail_cycle_ram.sv
module fail_cycle_ram #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rd_q <= mem[raddr];
  end

  assign rdata = rd_q;
endmodule

// File: rtl/endurance_sequencer.sv
module endurance_sequencer
  import endurance_pkg::*;
#(
  parameter int BLK_AW      = 12,
  parameter int PAGES       = 64,
  parameter int MAX_SAMPLES = 16,
  parameter int TMO_W       = 20,
  parameter int CYC_W       = 32,
  localparam int PG_W  = $clog2(PAGES),
  localparam int SI_W  = $clog2(MAX_SAMPLES + 1),
  localparam int RA_W  = $clog2(MAX_SAMPLES),
  localparam int SUM_W = CYC_W + SI_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [BLK_AW:0]   total_blocks,
  input  logic [SI_W-1:0]   sample_count,
  input  logic [TMO_W-1:0]  erase_limit,
  input  logic [TMO_W-1:0]  prog_limit,
  output logic              op_start,
  output logic              op_kind,
  output logic [BLK_AW-1:0] op_block,
  output logic [PG_W-1:0]   op_page,
  input  logic              op_done,
  input  logic              op_fail,
  output logic              busy,
  output logic              result_valid,
  output logic [CYC_W-1:0]  result_avg
);
  seq_state_t state_q;
  logic [SI_W-1:0]        idx_q, remain_q, rd_idx_q;
  logic [CYC_W-1:0]       pass_q, res_q;
  logic [MAX_SAMPLES-1:0] alive_q;
  logic [PG_W-1:0]        page_q;
  logic                   kind_q, start_q, busy_q, resv_q, rd_vld_q;
  logic [TMO_W-1:0]       wcnt_q, lim;
  logic [SUM_W-1:0]       sum_q, div_num, div_quo;
  logic [BLK_AW+1:0]      step_q;
  logic [BLK_AW:0]        w_addr;
  logic [CYC_W-1:0]       rd_data;
  logic [RA_W-1:0]        ra;
  logic div_go, div_done, w_load, w_adv;
  logic sel_end, sel_skip, blk_fin, blk_fail, sum_end, op_ok;

  always_comb begin
    ra       = idx_q[RA_W-1:0];
    lim      = (kind_q == OPK_ERASE) ? erase_limit : prog_limit;
    sel_end  = (state_q == ST_SEL) && (idx_q == sample_count);
    sel_skip = (state_q == ST_SEL) && !sel_end && !alive_q[ra];
    op_ok    = (state_q == ST_WAIT) && op_done && !op_fail;
    blk_fin  = op_ok && (kind_q == OPK_PROG) && (page_q == PG_W'(PAGES - 1));
    blk_fail = (state_q == ST_WAIT) &&
               ((op_done && op_fail) || (!op_done && wcnt_q == lim));
    sum_end  = (state_q == ST_SUM) && (rd_idx_q == sample_count) && !rd_vld_q;
    div_go   = ((state_q == ST_IDLE) && start) || sum_end;
    div_num  = (state_q == ST_IDLE) ? SUM_W'(total_blocks) : sum_q;
    w_load   = ((state_q == ST_IDLE) && start) || (sel_end && remain_q != '0);
    w_adv    = sel_skip || blk_fin || blk_fail;
  end

  seq_divider #(.W(SUM_W)) u_div (
    .clk(clk), .rst(rst), .go(div_go), .num(div_num),
    .den(SUM_W'(sample_count)), .done(div_done), .quo(div_quo)
  );

  sample_addr_walker #(.AW(BLK_AW)) u_walk (
    .clk(clk), .rst(rst), .load(w_load), .adv(w_adv),
    .total(total_blocks), .step(step_q), .addr(w_addr)
  );

  fail_cycle_ram #(.DEPTH(MAX_SAMPLES), .DW(CYC_W)) u_ram (
    .clk(clk), .we(blk_fail), .waddr(ra), .wdata(pass_q),
    .raddr(rd_idx_q[RA_W-1:0]), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      remain_q <= '0;
      rd_idx_q <= '0;
      pass_q   <= '0;
      res_q    <= '0;
      alive_q  <= '0;
      page_q   <= '0;
      kind_q   <= OPK_ERASE;
      start_q  <= 1'b0;
      busy_q   <= 1'b0;
      resv_q   <= 1'b0;
      rd_vld_q <= 1'b0;
      wcnt_q   <= '0;
      sum_q    <= '0;
      step_q   <= '0;
    end else begin
      start_q <= 1'b0;
      resv_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start) begin
          pass_q   <= CYC_W'(1);
          idx_q    <= '0;
          remain_q <= sample_count;
          busy_q   <= 1'b1;
          for (int j = 0; j < MAX_SAMPLES; j++)
            alive_q[j] <= (SI_W'(j) < sample_count);
          state_q  <= ST_STRIDE;
        end
        ST_STRIDE: if (div_done) begin
          step_q  <= div_quo[BLK_AW+1:0] + {{(BLK_AW+1){1'b0}}, 1'b1};
          state_q <= ST_SEL;
        end
        ST_SEL: begin
          if (sel_end) begin
            if (remain_q == '0) begin
              sum_q    <= '0;
              rd_idx_q <= '0;
              rd_vld_q <= 1'b0;
              state_q  <= ST_SUM;
            end else begin
              pass_q <= pass_q + 1'b1;
              idx_q  <= '0;
            end
          end else if (alive_q[ra]) begin
            kind_q  <= OPK_ERASE;
            page_q  <= '0;
            state_q <= ST_ISSUE;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_ISSUE: begin
          start_q <= 1'b1;
          wcnt_q  <= TMO_W'(1);
          state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (blk_fail) begin
            alive_q[ra] <= 1'b0;
            remain_q    <= remain_q - 1'b1;
            idx_q       <= idx_q + 1'b1;
            state_q     <= ST_SEL;
          end else if (blk_fin) begin
            idx_q   <= idx_q + 1'b1;
            state_q <= ST_SEL;
          end else if (op_ok) begin
            if (kind_q == OPK_ERASE) kind_q <= OPK_PROG;
            else page_q <= page_q + 1'b1;
            state_q <= ST_ISSUE;
          end else begin
            wcnt_q <= wcnt_q + 1'b1;
          end
        end
        ST_SUM: begin
          if (rd_idx_q != sample_count) begin
            rd_idx_q <= rd_idx_q + 1'b1;
            rd_vld_q <= 1'b1;
          end else begin
            rd_vld_q <= 1'b0;
          end
          if (rd_vld_q) sum_q <= sum_q + SUM_W'(rd_data);
          if (sum_end) state_q <= ST_DIV;
        end
        ST_DIV: if (div_done) begin
          res_q   <= div_quo[CYC_W-1:0];
          resv_q  <= 1'b1;
          busy_q  <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign op_start     = start_q;
  assign op_kind      = kind_q;
  assign op_block     = w_addr[BLK_AW-1:0];
  assign op_page      = page_q;
  assign busy         = busy_q;
  assign result_valid = resv_q;
  assign result_avg   = res_q;

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
    op_start |=> !op_start); // R5
  AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    op_start |-> w_addr < total_blocks); // R3
  AST_ERASE_PAGE0: assert property (@(posedge clk) disable iff (rst)
    (op_start && op_kind == OPK_ERASE) |-> op_page == '0); // R4
  AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> !result_valid); // R9
  AST_IDLE_AT_RESULT: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> !busy); // R9
  AST_AVG_FITS: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DIV && div_done) |-> div_quo[SUM_W-1:CYC_W] == '0); // R9
  AST_OPS_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    op_start |-> busy); // R2
endmodule

// File: tb/sim_endurance_sequencer.sv
module sim_endurance_sequencer;
  localparam int BLK_AW = 12, PAGES = 64, MAXS = 16, TMO_W = 20, CYC_W = 32;
  localparam int SI_W = $clog2(MAXS + 1), PG_W = $clog2(PAGES);
  localparam int ELIM = 8, PLIM = 8;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [BLK_AW:0] total_blocks = '0;
  logic [SI_W-1:0] sample_count = '0;
  logic [TMO_W-1:0] erase_limit = TMO_W'(ELIM), prog_limit = TMO_W'(PLIM);
  logic op_start, op_kind, busy, result_valid;
  logic [BLK_AW-1:0] op_block;
  logic [PG_W-1:0] op_page;
  logic op_done = 1'b0, op_fail = 1'b0;
  logic [CYC_W-1:0] result_avg;

  always #2.5 clk = ~clk;

  endurance_sequencer #(.BLK_AW(BLK_AW), .PAGES(PAGES), .MAX_SAMPLES(MAXS),
    .TMO_W(TMO_W), .CYC_W(CYC_W)) u0 (
    .clk(clk), .rst(rst), .start(start), .total_blocks(total_blocks),
    .sample_count(sample_count), .erase_limit(erase_limit),
    .prog_limit(prog_limit), .op_start(op_start), .op_kind(op_kind),
    .op_block(op_block), .op_page(op_page), .op_done(op_done),
    .op_fail(op_fail), .busy(busy), .result_valid(result_valid),
    .result_avg(result_avg));

  int checks = 0, errors = 0, ncyc = 0;
  int wear_at [4096];
  int mode_at [4096];   // 0 fail status on erase, 1 erase never answers, 2 page 5 program fails
  int ecnt [4096];
  int expq [$];
  int cd = 0, pend_fail = 0, prev_start = 0, pulses = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // flash model and per-operation comparison with the reference stream
  always @(negedge clk) begin
    if (rst) begin
      cd = 0; op_done = 1'b0; op_fail = 1'b0; prev_start = 0;
    end else begin
      op_done = 1'b0;
      if (result_valid) pulses++;
      if (cd > 0) begin
        cd--;
        if (cd == 0) begin op_done = 1'b1; op_fail = pend_fail[0]; end
      end
      if (op_start) begin
        int b, code, want;
        chk(!prev_start && cd == 0, "R5", "op_start while outstanding", 1, 0);
        b = int'(op_block);
        code = int'(op_kind) * 1000000 + b * 1000 + int'(op_page);
        want = (expq.size() > 0) ? expq.pop_front() : -1;
        chk(code == want, "R3/R4 R6", "operation code", code, want);
        pend_fail = 0;
        cd = op_kind ? 2 : 3;
        if (!op_kind) begin
          ecnt[b]++;
          if (ecnt[b] >= wear_at[b] && mode_at[b] == 0) pend_fail = 1;
          if (ecnt[b] >= wear_at[b] && mode_at[b] == 1) cd = 0;
        end else if (mode_at[b] == 2 && ecnt[b] == wear_at[b] && op_page == 5) begin
          pend_fail = 1;
        end
      end
      prev_start = int'(op_start);
    end
  end

  always @(posedge clk) begin
    ncyc++;
    if (ncyc > 190000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", ncyc, 190000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // reference: build the expected operation stream from the requirements
  task automatic build(input int t, input int s, output int avg);
    int addr [16];
    bit alive [16];
    int left, pass, sum;
    expq.delete();
    left = s; pass = 0; sum = 0;
    for (int i = 0; i < s; i++) begin
      addr[i] = (i * (t / s) + i) % t;  // R3
      alive[i] = 1'b1;
    end
    while (left > 0) begin
      pass++;                           // R8
      for (int i = 0; i < s; i++) begin
        int b;
        if (!alive[i]) continue;
        b = addr[i];
        expq.push_back(b * 1000);
        if (pass >= wear_at[b] && mode_at[b] != 2) begin
          alive[i] = 1'b0; left--; sum += pass; continue;
        end
        for (int p = 0; p < PAGES; p++) begin
          expq.push_back(1000000 + b * 1000 + p);
          if (mode_at[b] == 2 && pass == wear_at[b] && p == 5) begin
            alive[i] = 1'b0; left--; sum += pass; break;
          end
        end
      end
    end
    avg = sum / s;
  endtask

  task automatic run(input int t, input int s, input bit poke);
    int avg;
    build(t, s, avg);
    for (int b = 0; b < 4096; b++) ecnt[b] = 0;
    total_blocks = (BLK_AW+1)'(t);
    sample_count = SI_W'(s);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !op_start && !result_valid, "R1", "reset outputs",
        {busy, op_start, result_valid}, 0);
    pulses = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R2", "busy after start", busy, 1);
    if (poke) begin
      repeat (300) @(negedge clk);
      start = 1'b1;                     // R2: must be ignored mid-run
      @(negedge clk);
      start = 1'b0;
    end
    while (!result_valid) @(negedge clk);
    chk(result_avg == CYC_W'(avg), "R9", "average", result_avg, avg);
    chk(!busy, "R9", "busy low at result", busy, 0);
    chk(expq.size() == 0, "R6 R7", "ops left unissued", expq.size(), 0);
    repeat (3) @(negedge clk);
    chk(!result_valid && pulses == 1, "R9", "result strobe count", pulses, 1);
    chk(result_avg == CYC_W'(avg), "R9", "result held", result_avg, avg);
    chk(!busy && !op_start, "R2", "no activity after run", busy, 0);
  endtask

  initial begin
    for (int b = 0; b < 4096; b++) begin wear_at[b] = 1000; mode_at[b] = 0; end
    // four samples on 64 blocks: 0,17,34,51
    wear_at[0] = 3;  mode_at[0] = 0;
    wear_at[17] = 1; mode_at[17] = 0;
    wear_at[34] = 4; mode_at[34] = 2;   // R6 program fail mid-block
    wear_at[51] = 2; mode_at[51] = 0;
    run(64, 4, 1'b1);
    // three samples on 50 blocks: 0,17,34, with an erase timeout (R7)
    wear_at[0] = 2;  mode_at[0] = 1;
    wear_at[17] = 3; mode_at[17] = 0;
    wear_at[34] = 3; mode_at[34] = 2;
    run(50, 3, 1'b0);
    // single sample
    wear_at[0] = 2; mode_at[0] = 0;
    run(50, 1, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule